// File: doc/BRIEF.md
# DAC Output Update Controller

This block decides which code drives a precision DAC output and when that code changes. It stores three values: a pending DAC register, a clear code and the output code that is currently applied. Upstream logic writes the DAC register and the clear code through simple write strobes. Three active-low control pins (load, clear and device reset) and three one-cycle software command pulses (load, clear and reset) then determine whether the output follows the DAC register, jumps to the clear code, holds, or returns to the power-on state.

The pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer, and edges are detected against the previous synchronized value. Each software command is masked by the level of the opposite pin: the software clear is ignored while the load pin is low, and the software load is ignored while the clear pin is low. While the reset pin is low the block holds its defaults, ignores all programming, and raises a flag so that neighbouring logic can refuse accesses.

Top module: `dac_update_ctrl`

## Requirements
- R1: After `rst_n` is released with all three pins high, `out_code` is 0 and `reset_active` is 0.
- R2: While the synchronized reset pin is low, `reset_active` is 1, `out_code` is 0, and DAC-register and clear-code writes are ignored.
- R3: When the reset pin rises, the output code, the DAC register and the clear code all stand at their power-on value of 0.
- R4: While the clear pin is low, the DAC register and `out_code` both take the clear code on every cycle, whatever the load pin level. A DAC-register write in such a cycle is overwritten.
- R5: While the clear pin is high and the load pin is low, `out_code` equals the DAC register one cycle after each write.
- R6: While both pins are high and no software command is issued, `out_code` holds. A falling load edge applies the DAC register, and a rising load edge leaves the output unchanged.
- R7: When the clear pin rises with the load pin high, the output keeps the clear code. With the load pin low, the output goes back to tracking the DAC register, which now holds the clear code.
- R8: A software load pulse with both pins high copies the DAC register to `out_code`. The pulse has no effect while the clear pin is low.
- R9: A software clear pulse with the load pin high loads the clear code into the DAC register and `out_code`. The pulse has no effect while the load pin is low.
- R10: A software reset pulse returns the output code, the DAC register and the clear code to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ldac_n | input | 1 | Active-low load pin, asynchronous |
| clr_n | input | 1 | Active-low clear pin, asynchronous |
| reset_n | input | 1 | Active-low device reset pin, asynchronous |
| sw_ldac | input | 1 | One-cycle software load command |
| sw_clr | input | 1 | One-cycle software clear command |
| sw_reset | input | 1 | One-cycle software reset command |
| dac_wr | input | 1 | Write strobe for the DAC register |
| dac_wr_data | input | CODE_W | Data for the DAC register |
| cc_wr | input | 1 | Write strobe for the clear code |
| cc_wr_data | input | CODE_W | Data for the clear code |
| out_code | output | CODE_W | Code currently applied to the output |
| reset_active | output | 1 | High while the device reset pin holds the block |

## Verification
Two cases can fall in the same cycle: a DAC-register write while the clear pin is low, and a software load pulse while the clear pin is low. The bench provokes both on purpose. The write must lose to the clear-code load. This is judged after the clear pin is released with the load pin high: a software load then has to show the clear code and not the written value. The masked software load must leave the output at the clear code. The same masking is checked from the other side by pulsing the software clear while the load pin is low.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int NUM_PINS = 3;

  typedef enum int unsigned {
    PIN_LDAC = 0,
    PIN_CLR  = 1,
    PIN_RST  = 2
  } pin_idx_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [CHAIN-1:0] chain_q;
    logic [CHAIN-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN-2:0], pin_n[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    // The last stage holds the previous synchronized value.
    assign lvl[g]  = chain_q[STAGES-1];
    assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/code_regs.sv
module code_regs #(
  parameter int CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              load_clr,
  input  logic              dac_wr,
  input  logic [CODE_W-1:0] dac_data,
  input  logic              cc_wr,
  input  logic [CODE_W-1:0] cc_data,
  output logic [CODE_W-1:0] dac_q,
  output logic [CODE_W-1:0] cc_q
);
  logic [CODE_W-1:0] dac_d, cc_d;
  logic              dac_en, cc_en;

  always_comb begin
    dac_en = kill | load_clr | dac_wr;
    cc_en  = kill | cc_wr;
    if (kill)          dac_d = '0;
    else if (load_clr) dac_d = cc_q;
    else               dac_d = dac_data;
    cc_d = kill ? '0 : cc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      cc_q  <= '0;
    end else begin
      if (dac_en) dac_q <= dac_d;
      if (cc_en)  cc_q  <= cc_d;
    end
  end

  assert_kill_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (dac_q == '0 && cc_q == '0));
endmodule

// File: rtl/out_select.sv
module out_select #(
  parameter int CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              load_clr,
  input  logic              apply_dac,
  input  logic [CODE_W-1:0] dac_q,
  input  logic [CODE_W-1:0] cc_q,
  output logic [CODE_W-1:0] out_q
);
  logic [CODE_W-1:0] out_d;
  logic              out_en;

  always_comb begin
    out_en = kill | load_clr | apply_dac;
    if (kill)          out_d = '0;
    else if (load_clr) out_d = cc_q;
    else               out_d = dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !load_clr && !apply_dac) |=> $stable(out_q));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              reset_n,
  input  logic              sw_ldac,
  input  logic              sw_clr,
  input  logic              sw_reset,
  input  logic              dac_wr,
  input  logic [CODE_W-1:0] dac_wr_data,
  input  logic              cc_wr,
  input  logic [CODE_W-1:0] cc_wr_data,
  output logic [CODE_W-1:0] out_code,
  output logic              reset_active
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_PINS-1:0] pins_n, p_lvl, p_rise, p_fall;

  always_comb begin
    pins_n           = '1;
    pins_n[PIN_LDAC] = ldac_n;
    pins_n[PIN_CLR]  = clr_n;
    pins_n[PIN_RST]  = reset_n;
  end

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pin_n (pins_n),
    .lvl   (p_lvl),
    .rise  (p_rise),
    .fall  (p_fall)
  );

  logic ldac_lvl, clr_lvl, rst_lvl, rst_rise;
  logic kill, load_clr, apply_dac;
  logic [CODE_W-1:0] dac_q, cc_q;

  assign ldac_lvl = p_lvl[PIN_LDAC];
  assign clr_lvl  = p_lvl[PIN_CLR];
  assign rst_lvl  = p_lvl[PIN_RST];
  assign rst_rise = p_rise[PIN_RST];

  // Control decode: reset dominates, the clear pin masks the software load,
  // and the load pin masks the software clear.
  always_comb begin
    kill      = ~rst_lvl | rst_rise | sw_reset;
    load_clr  = ~clr_lvl | (sw_clr & ldac_lvl);
    apply_dac = clr_lvl & (~ldac_lvl | p_fall[PIN_LDAC] | sw_ldac);
  end

  code_regs #(.CODE_W(CODE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .kill     (kill),
    .load_clr (load_clr),
    .dac_wr   (dac_wr),
    .dac_data (dac_wr_data),
    .cc_wr    (cc_wr),
    .cc_data  (cc_wr_data),
    .dac_q    (dac_q),
    .cc_q     (cc_q)
  );

  out_select #(.CODE_W(CODE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .kill      (kill),
    .load_clr  (load_clr),
    .apply_dac (apply_dac),
    .dac_q     (dac_q),
    .cc_q      (cc_q),
    .out_q     (out_code)
  );

  assign reset_active = ~rst_lvl;

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_active |=> (out_code == '0));

  assert_sw_reset_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_reset |=> (out_code == '0));

  assert_clr_level_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_lvl && !reset_active && !sw_reset) |=> (out_code == $past(cc_q)));

  assert_track_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_lvl && !ldac_lvl && !reset_active && !sw_reset) |=> (out_code == $past(dac_q)));

  assert_rise_defaults_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_rise |=> (out_code == '0 && !reset_active));
endmodule

// File: tb/sim_dac_update_ctrl.sv
module sim_dac_update_ctrl;
  localparam int  CODE_W     = 20;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, ldac_n, clr_n, reset_n;
  logic sw_ldac, sw_clr, sw_reset, dac_wr, cc_wr;
  logic [CODE_W-1:0] dac_wr_data, cc_wr_data, out_code;
  logic reset_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [CODE_W-1:0] q_code[$];
  logic              q_ra[$];
  string             q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_ctrl #(.CODE_W(CODE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n), .clr_n(clr_n), .reset_n(reset_n),
    .sw_ldac(sw_ldac), .sw_clr(sw_clr), .sw_reset(sw_reset),
    .dac_wr(dac_wr), .dac_wr_data(dac_wr_data),
    .cc_wr(cc_wr), .cc_wr_data(cc_wr_data),
    .out_code(out_code), .reset_active(reset_active)
  );

  // Monitor: pops expected items and compares away from the rising edge.
  always @(negedge clk) begin
    #1;
    while (q_code.size() > 0) begin
      logic [CODE_W-1:0] ec;
      logic              er;
      string             t;
      ec = q_code.pop_front();
      er = q_ra.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (out_code !== ec || reset_active !== er) begin
        fails++;
        $display("FAIL %s: out_code=%h reset_active=%b expected out_code=%h reset_active=%b",
                 t, out_code, reset_active, ec, er);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic [CODE_W-1:0] c, logic ra, string t);
    q_code.push_back(c);
    q_ra.push_back(ra);
    q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr_dac(logic [CODE_W-1:0] v);
    @(negedge clk); dac_wr = 1'b1; dac_wr_data = v;
    @(negedge clk); dac_wr = 1'b0;
    idle(3);
  endtask

  task automatic wr_cc(logic [CODE_W-1:0] v);
    @(negedge clk); cc_wr = 1'b1; cc_wr_data = v;
    @(negedge clk); cc_wr = 1'b0;
    idle(3);
  endtask

  // which: 0 load, 1 clear, 2 reset
  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: sw_ldac = 1'b1;
      1: sw_clr = 1'b1;
      default: sw_reset = 1'b1;
    endcase
    @(negedge clk);
    sw_ldac = 1'b0; sw_clr = 1'b0; sw_reset = 1'b0;
    idle(3);
  endtask

  task automatic set_pins(logic l, logic c, logic r);
    @(negedge clk); ldac_n = l; clr_n = c; reset_n = r;
    idle(5);
  endtask

  initial begin
    rst_n = 1'b0; ldac_n = 1'b1; clr_n = 1'b1; reset_n = 1'b1;
    sw_ldac = 1'b0; sw_clr = 1'b0; sw_reset = 1'b0;
    dac_wr = 1'b0; cc_wr = 1'b0; dac_wr_data = '0; cc_wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    expect_out(20'h00000, 1'b0, "R1 reset state");

    wr_dac(20'h12345);
    wr_cc(20'hFFFFF);
    expect_out(20'h00000, 1'b0, "R6 load pin high holds output");
    pulse(0);
    expect_out(20'h12345, 1'b0, "R8 software load applies");

    set_pins(1'b0, 1'b1, 1'b1);
    wr_dac(20'h0ABCD);
    expect_out(20'h0ABCD, 1'b0, "R5 tracks while load low");
    set_pins(1'b1, 1'b1, 1'b1);
    expect_out(20'h0ABCD, 1'b0, "R6 load rising holds");
    wr_dac(20'h55555);
    expect_out(20'h0ABCD, 1'b0, "R6 write blocked while load high");
    set_pins(1'b0, 1'b1, 1'b1);
    expect_out(20'h55555, 1'b0, "R6 load falling applies");

    pulse(1);
    expect_out(20'h55555, 1'b0, "R9 software clear masked by load low");
    set_pins(1'b1, 1'b1, 1'b1);
    pulse(1);
    expect_out(20'hFFFFF, 1'b0, "R9 software clear loads clear code");
    wr_dac(20'h00777);
    expect_out(20'hFFFFF, 1'b0, "R6 hold after clear");
    pulse(0);
    expect_out(20'h00777, 1'b0, "R8 software load after write");

    // Clear pin low with load high; collide a write and a software load.
    set_pins(1'b1, 1'b0, 1'b1);
    expect_out(20'hFFFFF, 1'b0, "R4 clear pin applies clear code");
    wr_dac(20'h33333);
    expect_out(20'hFFFFF, 1'b0, "R4 write overridden by clear");
    pulse(0);
    expect_out(20'hFFFFF, 1'b0, "R8 software load masked by clear low");
    set_pins(1'b1, 1'b1, 1'b1);
    expect_out(20'hFFFFF, 1'b0, "R7 clear rising with load high keeps clear code");
    wr_cc(20'h00042);
    pulse(0);
    expect_out(20'hFFFFF, 1'b0, "R4 DAC register holds clear code, not the write");

    set_pins(1'b0, 1'b0, 1'b1);
    expect_out(20'h00042, 1'b0, "R4 clear low with load low");
    set_pins(1'b0, 1'b1, 1'b1);
    expect_out(20'h00042, 1'b0, "R7 clear rising with load low tracks DAC register");
    wr_dac(20'h9876A);
    expect_out(20'h9876A, 1'b0, "R7 tracking resumed");

    set_pins(1'b0, 1'b1, 1'b0);
    expect_out(20'h00000, 1'b1, "R2 reset pin held");
    wr_dac(20'h11111);
    wr_cc(20'h22222);
    expect_out(20'h00000, 1'b1, "R2 writes ignored in reset");
    set_pins(1'b0, 1'b1, 1'b1);
    expect_out(20'h00000, 1'b0, "R3 defaults after reset rise");
    set_pins(1'b0, 1'b0, 1'b1);
    expect_out(20'h00000, 1'b0, "R3 clear code at default");
    set_pins(1'b0, 1'b1, 1'b1);

    wr_cc(20'h0F0F0);
    wr_dac(20'h0C0DE);
    expect_out(20'h0C0DE, 1'b0, "R5 tracking before software reset");
    pulse(2);
    expect_out(20'h00000, 1'b0, "R10 software reset clears output");
    set_pins(1'b1, 1'b0, 1'b1);
    expect_out(20'h00000, 1'b0, "R10 software reset clears clear code");
    set_pins(1'b1, 1'b1, 1'b1);
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule